// File: doc/BRIEF.md
# Floating-Point Operand Register Bank with Compare Flag

This block is the operand storage of a floating-point coprocessor. It holds thirty-two 32-bit words. Each word can be addressed on its own as a single-precision operand. Adjacent words can also be addressed in pairs as one 64-bit double-precision operand. A pair is named by its even index. The even word carries the low half and the next odd word carries the high half.

The bank has two operand read ports and one result write port, and each of them can work in either width. Three more paths carry single words:
- a move path that takes a word in from the integer core,
- a load path that takes a word in from memory,
- two combinational read taps that give words back to the core and to the store datapath.

The bank also keeps one hidden condition bit. Compares of either precision write it, and the branch unit reads it through a taken/not-taken output.

The arithmetic units, the decoder and the address generation sit outside the block. They only drive these ports.

Top module: `fpr_bank`

## Requirements
- R1: The reset input is synchronous and active-high. One rising edge with it high clears all 32 words and the condition bit to zero.
- R2: A single-width write stores `res_data[31:0]` into word `res_idx` and ignores the upper half. A single-width read returns the addressed word in bits 31:0 and zeros in bits 63:32.
- R3: A double-width read at an even index n returns word n in bits 31:0 and word n+1 in bits 63:32.
- R4: A double-width write at an even index n stores `res_data[31:0]` into word n and `res_data[63:32]` into word n+1 on the same clock edge.
- R5: A double-width access with an odd index is misaligned, and its port's misalign output is high during that cycle. A misaligned read returns all zeros. A misaligned write leaves every word unchanged.
- R6: Reads are combinational and writes take effect at the rising edge. A read of a word that is being written in the same cycle returns the old contents, and the new contents are visible after the edge.
- R7: A core move-in writes one word into the file at the edge. The core read tap returns the addressed word combinationally.
- R8: A memory load writes one word into the file at the edge. The store read tap returns the addressed word combinationally.
- R9: When several write paths target the same word in one cycle, the result port wins over the core move-in, and the core move-in wins over the memory load.
- R10: When the compare strobe is high, the condition bit takes the compare result at the edge. When the strobe is low, the bit holds its value.
- R11: With a branch request, `br_taken` equals the condition bit when `br_on_true` is 1 and equals its inverse when `br_on_true` is 0. Without a request, `br_taken` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opa_idx | input | 5 | Operand port A word index |
| opa_dbl | input | 1 | Operand port A double-width select |
| opa_data | output | 64 | Operand port A data |
| opa_misalign | output | 1 | Port A double access at odd index |
| opb_idx | input | 5 | Operand port B word index |
| opb_dbl | input | 1 | Operand port B double-width select |
| opb_data | output | 64 | Operand port B data |
| opb_misalign | output | 1 | Port B double access at odd index |
| res_en | input | 1 | Result write enable |
| res_idx | input | 5 | Result write index |
| res_dbl | input | 1 | Result write double-width select |
| res_data | input | 64 | Result write data |
| res_misalign | output | 1 | Enabled double write at odd index |
| mvin_en | input | 1 | Core move-in enable |
| mvin_idx | input | 5 | Core move-in index |
| mvin_word | input | 32 | Core move-in word |
| mvout_idx | input | 5 | Core read tap index |
| mvout_word | output | 32 | Core read tap word |
| ld_en | input | 1 | Memory load enable |
| ld_idx | input | 5 | Memory load index |
| ld_word | input | 32 | Memory load word |
| st_idx | input | 5 | Store read tap index |
| st_word | output | 32 | Store read tap word |
| cmp_en | input | 1 | Compare result strobe |
| cmp_result | input | 1 | Compare outcome to capture |
| br_req | input | 1 | Branch evaluation request |
| br_on_true | input | 1 | 1 = branch on set, 0 = branch on clear |
| br_taken | output | 1 | Branch decision |

## Verification
Every read path and every misalign output is combinational, so the bench checks them in the same cycle as the stimulus, at the falling edge after the inputs change. A write, a compare capture or a reset shows up one rising edge later. The bench therefore samples the outcome at the falling edge that follows that rising edge and never earlier. The read-during-write case uses both sampling points on the same word: the old value before the edge and the new value after it.

// File: rtl/fpr_pkg.sv
`timescale 1ns/1ps
package fpr_pkg;
  localparam int DEF_REGS = 32;
  localparam int DEF_WORD = 32;

  // Which path updates a given word this cycle; later entries win.
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_LOAD = 2'd1,
    SRC_MOVE = 2'd2,
    SRC_RES  = 2'd3
  } wr_src_e;
endpackage

// File: rtl/fpr_store.sv
`timescale 1ns/1ps
module fpr_store
  import fpr_pkg::*;
#(
  parameter int NUM_REGS = DEF_REGS,
  parameter int WORD_W   = DEF_WORD,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int DW      = 2 * WORD_W
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              res_en,
  input  logic [IDX_W-1:0]                  res_idx,
  input  logic                              res_dbl,
  input  logic [DW-1:0]                     res_data,
  input  logic                              mv_en,
  input  logic [IDX_W-1:0]                  mv_idx,
  input  logic [WORD_W-1:0]                 mv_word,
  input  logic                              ld_en,
  input  logic [IDX_W-1:0]                  ld_idx,
  input  logic [WORD_W-1:0]                 ld_word,
  output logic [NUM_REGS-1:0][WORD_W-1:0]   regs,
  output logic                              res_misalign
);
  logic res_ok;

  assign res_misalign = res_en && res_dbl && res_idx[0];
  assign res_ok       = res_en && !res_misalign;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
    wr_src_e           src;
    logic [WORD_W-1:0] nxt;
    logic              hi_hit;

    if (g % 2 == 1) begin : g_odd
      assign hi_hit = res_ok && res_dbl && ((res_idx | IDX_W'(1)) == IDX_W'(g));
    end else begin : g_even
      assign hi_hit = 1'b0;
    end

    always_comb begin
      src = SRC_NONE;
      nxt = regs[g];
      if (ld_en && ld_idx == IDX_W'(g)) begin
        src = SRC_LOAD;
        nxt = ld_word;
      end
      if (mv_en && mv_idx == IDX_W'(g)) begin
        src = SRC_MOVE;
        nxt = mv_word;
      end
      if (res_ok && res_idx == IDX_W'(g)) begin
        src = SRC_RES;
        nxt = res_data[WORD_W-1:0];
      end
      if (hi_hit) begin
        src = SRC_RES;
        nxt = res_data[DW-1:WORD_W];
      end
    end

    always_ff @(posedge clk) begin
      if (rst)                 regs[g] <= '0;
      else if (src != SRC_NONE) regs[g] <= nxt;
    end
  end

  AST_MISALIGN_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (res_misalign && !mv_en && !ld_en) |=> $stable(regs)) else $error("misaligned write changed file"); // R5

  AST_PAIR_WRITE: assert property (@(posedge clk) disable iff (rst)
    (res_en && res_dbl && !res_idx[0] && !mv_en && !ld_en) |=>
      (regs[$past(res_idx)] == $past(res_data[WORD_W-1:0])) &&
      (regs[$past(res_idx | IDX_W'(1))] == $past(res_data[DW-1:WORD_W]))) else $error("pair write lost"); // R4

  AST_SINGLE_WRITE: assert property (@(posedge clk) disable iff (rst)
    (res_en && !res_dbl) |=> regs[$past(res_idx)] == $past(res_data[WORD_W-1:0])) else $error("single write lost"); // R2

  AST_MOVE_OVER_LOAD: assert property (@(posedge clk) disable iff (rst)
    (mv_en && !res_en) |=> regs[$past(mv_idx)] == $past(mv_word)) else $error("move-in lost"); // R9
endmodule

// File: rtl/fpr_rdport.sv
`timescale 1ns/1ps
module fpr_rdport
  import fpr_pkg::*;
#(
  parameter int NUM_REGS = DEF_REGS,
  parameter int WORD_W   = DEF_WORD,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int DW      = 2 * WORD_W
) (
  input  logic [NUM_REGS-1:0][WORD_W-1:0] regs,
  input  logic [IDX_W-1:0]                idx,
  input  logic                            dbl,
  output logic [DW-1:0]                   data,
  output logic                            misalign
);
  assign misalign = dbl && idx[0];

  always_comb begin
    if (!dbl)         data = {{WORD_W{1'b0}}, regs[idx]};
    else if (misalign) data = '0;
    else              data = {regs[idx | IDX_W'(1)], regs[idx]};
  end
endmodule

// File: rtl/fpr_cond.sv
`timescale 1ns/1ps
module fpr_cond (
  input  logic clk,
  input  logic rst,
  input  logic cmp_en,
  input  logic cmp_result,
  input  logic br_req,
  input  logic br_on_true,
  output logic br_taken
);
  logic cond_q;

  always_ff @(posedge clk) begin
    if (rst)         cond_q <= 1'b0;
    else if (cmp_en) cond_q <= cmp_result;
  end

  assign br_taken = br_req && (cond_q == br_on_true);

  AST_COND_HOLD: assert property (@(posedge clk) disable iff (rst)
    !cmp_en |=> $stable(cond_q)) else $error("flag moved without compare"); // R10

  AST_COND_LOAD: assert property (@(posedge clk) disable iff (rst)
    cmp_en |=> cond_q == $past(cmp_result)) else $error("flag missed compare"); // R10

  AST_NO_REQ_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
    !br_req |-> !br_taken) else $error("branch without request"); // R11
endmodule

// File: rtl/fpr_bank.sv
`timescale 1ns/1ps
module fpr_bank
  import fpr_pkg::*;
#(
  parameter int NUM_REGS = DEF_REGS,
  parameter int WORD_W   = DEF_WORD,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int DW      = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  opa_idx,
  input  logic              opa_dbl,
  output logic [DW-1:0]     opa_data,
  output logic              opa_misalign,
  input  logic [IDX_W-1:0]  opb_idx,
  input  logic              opb_dbl,
  output logic [DW-1:0]     opb_data,
  output logic              opb_misalign,
  input  logic              res_en,
  input  logic [IDX_W-1:0]  res_idx,
  input  logic              res_dbl,
  input  logic [DW-1:0]     res_data,
  output logic              res_misalign,
  input  logic              mvin_en,
  input  logic [IDX_W-1:0]  mvin_idx,
  input  logic [WORD_W-1:0] mvin_word,
  input  logic [IDX_W-1:0]  mvout_idx,
  output logic [WORD_W-1:0] mvout_word,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [WORD_W-1:0] ld_word,
  input  logic [IDX_W-1:0]  st_idx,
  output logic [WORD_W-1:0] st_word,
  input  logic              cmp_en,
  input  logic              cmp_result,
  input  logic              br_req,
  input  logic              br_on_true,
  output logic              br_taken
);
  logic [NUM_REGS-1:0][WORD_W-1:0] regs;

  fpr_store #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_store (
    .clk(clk), .rst(rst),
    .res_en(res_en), .res_idx(res_idx), .res_dbl(res_dbl), .res_data(res_data),
    .mv_en(mvin_en), .mv_idx(mvin_idx), .mv_word(mvin_word),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_word(ld_word),
    .regs(regs), .res_misalign(res_misalign)
  );

  fpr_rdport #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_opa (
    .regs(regs), .idx(opa_idx), .dbl(opa_dbl), .data(opa_data), .misalign(opa_misalign)
  );

  fpr_rdport #(.NUM_REGS(NUM_REGS), .WORD_W(WORD_W)) u_opb (
    .regs(regs), .idx(opb_idx), .dbl(opb_dbl), .data(opb_data), .misalign(opb_misalign)
  );

  assign mvout_word = regs[mvout_idx];
  assign st_word    = regs[st_idx];

  fpr_cond u_cond (
    .clk(clk), .rst(rst), .cmp_en(cmp_en), .cmp_result(cmp_result),
    .br_req(br_req), .br_on_true(br_on_true), .br_taken(br_taken)
  );

  AST_MISALIGN_ZERO: assert property (@(posedge clk) disable iff (rst)
    opa_misalign |-> (opa_data == '0)) else $error("misaligned read not zero"); // R5

  AST_TAPS_AGREE: assert property (@(posedge clk) disable iff (rst)
    (mvout_idx == st_idx) |-> (mvout_word == st_word)) else $error("taps disagree"); // R7
endmodule

// File: tb/fpr_bank_test.sv
`timescale 1ns/1ps
module fpr_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  opa_idx = '0, opb_idx = '0, res_idx = '0, mvin_idx = '0;
  logic [4:0]  mvout_idx = '0, ld_idx = '0, st_idx = '0;
  logic        opa_dbl = 1'b0, opb_dbl = 1'b0, res_en = 1'b0, res_dbl = 1'b0;
  logic        mvin_en = 1'b0, ld_en = 1'b0, cmp_en = 1'b0, cmp_result = 1'b0;
  logic        br_req = 1'b0, br_on_true = 1'b0;
  logic [63:0] res_data = '0;
  logic [31:0] mvin_word = '0, ld_word = '0;
  logic [63:0] opa_data, opb_data;
  logic        opa_misalign, opb_misalign, res_misalign, br_taken;
  logic [31:0] mvout_word, st_word;

  logic [31:0] mdl [32];
  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  fpr_bank uut (
    .clk(clk), .rst(rst),
    .opa_idx(opa_idx), .opa_dbl(opa_dbl), .opa_data(opa_data), .opa_misalign(opa_misalign),
    .opb_idx(opb_idx), .opb_dbl(opb_dbl), .opb_data(opb_data), .opb_misalign(opb_misalign),
    .res_en(res_en), .res_idx(res_idx), .res_dbl(res_dbl), .res_data(res_data),
    .res_misalign(res_misalign),
    .mvin_en(mvin_en), .mvin_idx(mvin_idx), .mvin_word(mvin_word),
    .mvout_idx(mvout_idx), .mvout_word(mvout_word),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_word(ld_word),
    .st_idx(st_idx), .st_word(st_word),
    .cmp_en(cmp_en), .cmp_result(cmp_result),
    .br_req(br_req), .br_on_true(br_on_true), .br_taken(br_taken)
  );

  function automatic logic [31:0] pat(input int i, input logic [31:0] salt);
    return (32'(i) * 32'h0103_0507) ^ salt;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic idle_writes();
    res_en = 1'b0; mvin_en = 1'b0; ld_en = 1'b0; cmp_en = 1'b0;
  endtask

  initial begin
    #100000;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", n_chk, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) mdl[i] = '0;
    step(); step();
    rst = 1'b0;

    // R1: every word cleared, flag clear
    for (int i = 0; i < 32; i++) begin
      opa_idx = 5'(i); opa_dbl = 1'b0;
      settle();
      chk(opa_data == 64'h0, "R1 reset word", opa_data, 64'h0);
      step();
    end
    br_req = 1'b1; br_on_true = 1'b0;
    settle();
    chk(br_taken == 1'b1, "R1 reset flag clear", 64'(br_taken), 64'h1);
    br_req = 1'b0;
    step();

    // R2: single writes to every word, upper half must be dropped
    for (int i = 0; i < 32; i++) begin
      res_en = 1'b1; res_dbl = 1'b0; res_idx = 5'(i);
      res_data = {32'hDEAD_BEEF, pat(i, 32'h5A5A_0F0F)};
      mdl[i] = pat(i, 32'h5A5A_0F0F);
      step();
    end
    idle_writes();
    for (int i = 0; i < 32; i++) begin
      opa_idx = 5'(i); opa_dbl = 1'b0;
      opb_idx = 5'(31 - i); opb_dbl = 1'b0;
      settle();
      chk(opa_data == {32'h0, mdl[i]}, "R2 single read A", opa_data, {32'h0, mdl[i]});
      chk(opb_data == {32'h0, mdl[31-i]}, "R2 single read B", opb_data, {32'h0, mdl[31-i]});
      step();
    end

    // R3: double reads on every even index
    for (int i = 0; i < 32; i += 2) begin
      opa_idx = 5'(i); opa_dbl = 1'b1;
      settle();
      chk(opa_data == {mdl[i+1], mdl[i]}, "R3 pair read", opa_data, {mdl[i+1], mdl[i]});
      chk(opa_misalign == 1'b0, "R3 aligned flag", 64'(opa_misalign), 64'h0);
      step();
    end

    // R4: double writes update both halves together
    for (int i = 0; i < 32; i += 2) begin
      res_en = 1'b1; res_dbl = 1'b1; res_idx = 5'(i);
      res_data = {pat(i + 1, 32'hC3C3_1234), pat(i, 32'h3C3C_8765)};
      mdl[i] = pat(i, 32'h3C3C_8765);
      mdl[i+1] = pat(i + 1, 32'hC3C3_1234);
      step();
      idle_writes();
      opb_idx = 5'(i); opb_dbl = 1'b1;
      opa_idx = 5'(i + 1); opa_dbl = 1'b0;
      settle();
      chk(opb_data == {mdl[i+1], mdl[i]}, "R4 pair write", opb_data, {mdl[i+1], mdl[i]});
      chk(opa_data == {32'h0, mdl[i+1]}, "R4 odd half", opa_data, {32'h0, mdl[i+1]});
      step();
    end

    // R5: odd-index doubles are flagged, read zero, write nothing
    for (int i = 1; i < 32; i += 2) begin
      res_en = 1'b1; res_dbl = 1'b1; res_idx = 5'(i); res_data = 64'hFFFF_FFFF_FFFF_FFFF;
      opa_idx = 5'(i); opa_dbl = 1'b1;
      opb_idx = 5'(i); opb_dbl = 1'b1;
      settle();
      chk(res_misalign == 1'b1, "R5 write misalign", 64'(res_misalign), 64'h1);
      chk(opa_misalign && opb_misalign, "R5 read misalign", {opa_misalign, opb_misalign}, 64'h3);
      chk(opa_data == 64'h0, "R5 misaligned read zero", opa_data, 64'h0);
      step();
      idle_writes();
      opa_idx = 5'(i); opa_dbl = 1'b0;
      opb_idx = 5'((i + 1) % 32); opb_dbl = 1'b0;
      settle();
      chk(opa_data == {32'h0, mdl[i]}, "R5 word kept", opa_data, {32'h0, mdl[i]});
      chk(opb_data == {32'h0, mdl[(i+1)%32]}, "R5 next word kept", opb_data, {32'h0, mdl[(i+1)%32]});
      step();
    end

    // R6: read-during-write sees old value, then new
    res_en = 1'b1; res_dbl = 1'b0; res_idx = 5'd7; res_data = 64'h0000_0000_7777_AAAA;
    opa_idx = 5'd7; opa_dbl = 1'b0;
    settle();
    chk(opa_data == {32'h0, mdl[7]}, "R6 old value during write", opa_data, {32'h0, mdl[7]});
    mdl[7] = 32'h7777_AAAA;
    step();
    idle_writes();
    settle();
    chk(opa_data == {32'h0, mdl[7]}, "R6 new value after edge", opa_data, {32'h0, mdl[7]});
    step();

    // R7: core move-in then read tap
    mvin_en = 1'b1; mvin_idx = 5'd12; mvin_word = 32'hC100_0000;
    mdl[12] = 32'hC100_0000;
    step();
    idle_writes();
    for (int i = 10; i < 14; i++) begin
      mvout_idx = 5'(i);
      settle();
      chk(mvout_word == mdl[i], "R7 core tap", 64'(mvout_word), 64'(mdl[i]));
      step();
    end

    // R8: memory load then store tap
    ld_en = 1'b1; ld_idx = 5'd20; ld_word = 32'hBE99_999A;
    mdl[20] = 32'hBE99_999A;
    step();
    idle_writes();
    for (int i = 19; i < 22; i++) begin
      st_idx = 5'(i);
      settle();
      chk(st_word == mdl[i], "R8 store tap", 64'(st_word), 64'(mdl[i]));
      step();
    end

    // R9: priority result > move-in > load
    res_en = 1'b1; res_dbl = 1'b0; res_idx = 5'd3; res_data = 64'h0000_0000_1111_1111;
    mvin_en = 1'b1; mvin_idx = 5'd3; mvin_word = 32'h2222_2222;
    ld_en = 1'b1; ld_idx = 5'd3; ld_word = 32'h3333_3333;
    mdl[3] = 32'h1111_1111;
    step();
    res_en = 1'b0;
    mvin_idx = 5'd4; ld_idx = 5'd4;
    mdl[4] = 32'h2222_2222;
    step();
    res_en = 1'b1; res_dbl = 1'b1; res_idx = 5'd8; res_data = 64'h4444_4444_5555_5555;
    mvin_en = 1'b1; mvin_idx = 5'd9; ld_en = 1'b0;
    mdl[8] = 32'h5555_5555; mdl[9] = 32'h4444_4444;
    step();
    idle_writes();
    opa_idx = 5'd3; opa_dbl = 1'b0; opb_idx = 5'd4; opb_dbl = 1'b0;
    settle();
    chk(opa_data == {32'h0, mdl[3]}, "R9 result over others", opa_data, {32'h0, mdl[3]});
    chk(opb_data == {32'h0, mdl[4]}, "R9 move over load", opb_data, {32'h0, mdl[4]});
    step();
    opa_idx = 5'd8; opa_dbl = 1'b1;
    settle();
    chk(opa_data == {mdl[9], mdl[8]}, "R9 pair high over move", opa_data, {mdl[9], mdl[8]});
    step();

    // R10 / R11: compare capture, hold, branch sense
    cmp_en = 1'b1; cmp_result = 1'b1;
    step();
    cmp_en = 1'b0; cmp_result = 1'b0;
    br_req = 1'b1; br_on_true = 1'b1;
    settle();
    chk(br_taken == 1'b1, "R10 captured set / R11 on-true", 64'(br_taken), 64'h1);
    step();
    br_on_true = 1'b0;
    settle();
    chk(br_taken == 1'b0, "R10 held while strobe low / R11 on-false", 64'(br_taken), 64'h0);
    br_req = 1'b0; br_on_true = 1'b1;
    settle();
    chk(br_taken == 1'b0, "R11 no request", 64'(br_taken), 64'h0);
    step();
    cmp_en = 1'b1; cmp_result = 1'b0;
    step();
    cmp_en = 1'b0;
    br_req = 1'b1; br_on_true = 1'b0;
    settle();
    chk(br_taken == 1'b1, "R10 captured clear", 64'(br_taken), 64'h1);
    step();
    br_req = 1'b0;

    // R1: reset mid-run clears again
    rst = 1'b1;
    step();
    rst = 1'b0;
    opa_idx = 5'd12; opa_dbl = 1'b0; br_req = 1'b1; br_on_true = 1'b1;
    settle();
    chk(opa_data == 64'h0, "R1 reset after use", opa_data, 64'h0);
    chk(br_taken == 1'b0, "R1 flag cleared", 64'(br_taken), 64'h0);
    step();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule